// File: doc/BRIEF.md
# Fetch Mode and Wait Timer Controller

This block sits beside the control sequencer of a small 8-bit microcoded processor and settles, each time an instruction fetch is about to begin, which of three modes governs it: ordinary execution, interrupt service or a timed wait. The sequencer raises `fetch_req` for one cycle at each fetch decision point. It also reports whether the instruction just finished chained its result into the next one (`prev_cascade`) and whether the next instruction is to be skipped (`cur_skip`). A mode change at that point takes effect from the following cycle, which is the fetch itself.

In interrupt mode the block selects the interrupt program-counter pair through `pc_sel_irq`, which feeds bit 2 of the register-bank address, and forces bit 7 of zero-page addresses through `zp_hi`. No vector is ever loaded. The interrupt counter simply keeps the address where the handler last released the line, so the handler behaves like a coroutine that resumes after its last yield. The wait timer is a pair of byte registers that instructions write. Once it is armed, it holds fetching off and counts down once per clock until it reaches zero. Counting stops while an interrupt is serviced and continues after the interrupt ends.

Top module: `fm_fetch_mode_ctl`

## Requirements
- R1: After reset, interrupt mode is off, the wait timer is off, `tmr_count` is 0, `fetch_go` is 1 and `fetch_mode` is 0.
- R2: At a permitted fetch point (`fetch_req`=1, `prev_cascade`=0, `cur_skip`=0, not stalled), interrupt mode in the next cycle equals the level of `irq_line`. This covers both entry and exit. Without a fetch point the mode does not change, except as described in R9.
- R3: A fetch point with `prev_cascade`=1 or `cur_skip`=1 changes nothing. An interrupt entry, an interrupt exit or a timer start is carried over to a later permitted fetch point.
- R4: `pc_sel_irq` and `zp_hi` are 1 exactly while interrupt mode is active. `fetch_mode` reads 0 in ordinary execution, 1 in interrupt mode and 2 while the timer stalls fetching.
- R5: `tmr_count` shows {high byte, low byte}. A write to the high byte alone loads that byte but never arms the timer.
- R6: A write to the low byte that leaves the 16-bit count V nonzero arms the timer. At the next permitted fetch point with `irq_line`=0, `fetch_go` drops from the next cycle and stays 0 for exactly V cycles. After that `tmr_count` is 0 and fetching resumes.
- R7: A write to the low byte that leaves both bytes zero disarms the timer or stops it, and a following fetch point does not stall.
- R8: While stalled, if the low byte is nonzero it decrements by one. If the low byte is 0, it becomes all-ones minus one (254 at 8 bits) with the high byte unchanged. In the next cycle the high byte decrements and the low byte holds.
- R9: If `irq_line` is 1 during a stall, interrupt mode starts in the next cycle with no fetch point, `fetch_go` returns to 1, and the count stays frozen while in interrupt mode.
- R10: When interrupt mode ends at a permitted fetch point, the stall resumes with the frozen remaining count and lasts exactly that many cycles.
- R11: A zero written to the low byte by the handler (high byte already zero) cancels the remaining wait, so interrupt exit returns straight to fetching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | 1 | Interrupt request level |
| fetch_req | input | 1 | One-cycle strobe marking a fetch decision point |
| prev_cascade | input | 1 | Previous instruction chained into the next one |
| cur_skip | input | 1 | Next instruction is to be skipped |
| tmr_wr_hi | input | 1 | Write strobe for the timer high byte |
| tmr_wr_lo | input | 1 | Write strobe for the timer low byte |
| tmr_wdata | input | BYTE_W | Data for timer byte writes |
| pc_sel_irq | output | 1 | 1 selects the interrupt program-counter pair |
| zp_hi | output | 1 | Forced bit 7 of zero-page addresses |
| fetch_go | output | 1 | 1 allows fetching, 0 stalls it for the timer |
| fetch_mode | output | 2 | 0 run, 1 interrupt, 2 timed wait |
| tmr_count | output | 2*BYTE_W | Current timer value {high, low} |

## Verification
The bench builds the block with its default BYTE_W of 8. This makes the wrap of the low byte to 254 and the delayed high-byte step real 16-bit events, not scaled-down ones. High-byte values are kept to 0, 1 or 2, so that whole waits spanning one or two high-byte borrows fit within a short run. Random interrupt toggling brings interrupts that land in mid-stall, exits at deferred fetch points, and timer writes coinciding with fetch points within reach of the reference model.

// File: rtl/fm_pkg.sv
package fm_pkg;

  typedef enum logic [1:0] {
    FM_RUN  = 2'd0,
    FM_IRQ  = 2'd1,
    FM_WAIT = 2'd2
  } fm_mode_e;

  // Mode reported to the sequencer: the stall takes precedence over the
  // interrupt flag, although the two are never both active by design.
  function automatic fm_mode_e mode_of(input logic irq_mode, input logic counting);
    if (counting)      return FM_WAIT;
    else if (irq_mode) return FM_IRQ;
    else               return FM_RUN;
  endfunction

endpackage

// File: rtl/fm_fetch_gate.sv
module fm_fetch_gate (
  input  logic fetch_req,
  input  logic prev_cascade,
  input  logic cur_skip,
  input  logic stalled,
  input  logic irq_line,
  output logic switch_ok,
  output logic start_ok
);

  // A mode may only change at a fetch point that is neither inside a
  // chained pair nor on a skipped instruction.
  assign switch_ok = fetch_req & ~prev_cascade & ~cur_skip & ~stalled;
  // A timer start loses to a pending interrupt at the same point.
  assign start_ok  = switch_ok & ~irq_line;

endmodule

// File: rtl/fm_irq_mode.sv
module fm_irq_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic switch_ok,
  input  logic stalled,
  input  logic irq_line,
  output logic irq_mode
);

  logic irq_mode_d;

  always_comb begin
    irq_mode_d = irq_mode;
    if (switch_ok)
      irq_mode_d = irq_line;
    else if (stalled && irq_line)
      irq_mode_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_mode <= 1'b0;
    else        irq_mode <= irq_mode_d;
  end

endmodule

// File: rtl/fm_wait_timer.sv
module fm_wait_timer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              start_ok,
  input  logic              irq_mode,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic              counting,
  output logic              reach_zero,
  output logic              wr_zero
);

  typedef struct packed {
    logic              brw;
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
  } cnt_t;

  // One clock of the wait: a pending borrow moves into the high byte,
  // otherwise the low byte steps down, wrapping by two on a zero low byte.
  function automatic cnt_t step_down(input cnt_t c);
    cnt_t r;
    r = c;
    if (c.brw) begin
      r.hi  = c.hi - BYTE_W'(1);
      r.brw = 1'b0;
    end else if (c.lo != '0) begin
      r.lo = c.lo - BYTE_W'(1);
    end else begin
      r.lo  = c.lo - BYTE_W'(2);
      r.brw = 1'b1;
    end
    return r;
  endfunction

  cnt_t cur_q, ld, dec, nxt;
  logic pend_q, wait_q;
  logic wr_any;

  assign wr_any   = wr_hi | wr_lo;
  assign counting = wait_q & ~irq_mode;

  always_comb begin
    ld.brw = 1'b0;
    ld.hi  = wr_hi ? wdata : cur_q.hi;
    ld.lo  = wr_lo ? wdata : cur_q.lo;
  end

  assign dec        = step_down(cur_q);
  assign reach_zero = counting & ~wr_any & (dec == '0);
  assign wr_zero    = wr_lo & (ld.hi == '0) & (ld.lo == '0);

  always_comb begin
    if (wr_any)        nxt = ld;
    else if (counting) nxt = dec;
    else               nxt = cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      pend_q <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      cur_q <= nxt;
      if (wr_zero || reach_zero) pend_q <= 1'b0;
      else if (wr_lo)            pend_q <= 1'b1;
      if (wr_zero || reach_zero)  wait_q <= 1'b0;
      else if (start_ok && pend_q) wait_q <= 1'b1;
    end
  end

  assign cnt_hi = cur_q.hi;
  assign cnt_lo = cur_q.lo;

endmodule

// File: rtl/fm_fetch_mode_ctl.sv
module fm_fetch_mode_ctl #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_line,
  input  logic                fetch_req,
  input  logic                prev_cascade,
  input  logic                cur_skip,
  input  logic                tmr_wr_hi,
  input  logic                tmr_wr_lo,
  input  logic [BYTE_W-1:0]   tmr_wdata,
  output logic                pc_sel_irq,
  output logic                zp_hi,
  output logic                fetch_go,
  output logic [1:0]          fetch_mode,
  output logic [2*BYTE_W-1:0] tmr_count
);

  localparam int CNT_W = 2 * BYTE_W;

  logic              switch_ok, start_ok;
  logic              irq_mode, counting;
  logic              reach_zero, wr_zero;
  logic [BYTE_W-1:0] cnt_hi, cnt_lo;

  fm_fetch_gate u_gate (
    .fetch_req    (fetch_req),
    .prev_cascade (prev_cascade),
    .cur_skip     (cur_skip),
    .stalled      (counting),
    .irq_line     (irq_line),
    .switch_ok    (switch_ok),
    .start_ok     (start_ok)
  );

  fm_irq_mode u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .switch_ok (switch_ok),
    .stalled   (counting),
    .irq_line  (irq_line),
    .irq_mode  (irq_mode)
  );

  fm_wait_timer #(.BYTE_W(BYTE_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hi      (tmr_wr_hi),
    .wr_lo      (tmr_wr_lo),
    .wdata      (tmr_wdata),
    .start_ok   (start_ok),
    .irq_mode   (irq_mode),
    .cnt_hi     (cnt_hi),
    .cnt_lo     (cnt_lo),
    .counting   (counting),
    .reach_zero (reach_zero),
    .wr_zero    (wr_zero)
  );

  logic [CNT_W-1:0] count_w;
  assign count_w    = {cnt_hi, cnt_lo};
  assign tmr_count  = count_w;
  assign pc_sel_irq = irq_mode;
  assign zp_hi      = irq_mode;
  assign fetch_go   = ~counting;
  assign fetch_mode = fm_pkg::mode_of(irq_mode, counting);

endmodule

// File: rtl/fm_fetch_mode_chk.sv
module fm_fetch_mode_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq_line,
  input logic                fetch_req,
  input logic                prev_cascade,
  input logic                cur_skip,
  input logic                tmr_wr_hi,
  input logic                tmr_wr_lo,
  input logic                pc_sel_irq,
  input logic                fetch_go,
  input logic [2*BYTE_W-1:0] tmr_count
);

  localparam logic [BYTE_W-1:0] LO_WRAP = {BYTE_W{1'b1}} - BYTE_W'(1);

  logic no_wr;
  assign no_wr = ~tmr_wr_hi & ~tmr_wr_lo;

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (tmr_count == '0 && !pc_sel_irq && fetch_go));

  p_fetch_point_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !prev_cascade && !cur_skip && fetch_go)
      |=> (pc_sel_irq == $past(irq_line)));

  p_deferred_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && (prev_cascade || cur_skip) && fetch_go)
      |=> ($stable(pc_sel_irq) && fetch_go));

  p_stall_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_go && no_wr) |=> (tmr_count != $past(tmr_count)));

  p_borrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_go && no_wr && tmr_count[BYTE_W-1:0] == '0)
      |=> (tmr_count[BYTE_W-1:0] == LO_WRAP));

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_sel_irq && no_wr) |=> $stable(tmr_count));

endmodule

bind fm_fetch_mode_ctl fm_fetch_mode_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_line     (irq_line),
  .fetch_req    (fetch_req),
  .prev_cascade (prev_cascade),
  .cur_skip     (cur_skip),
  .tmr_wr_hi    (tmr_wr_hi),
  .tmr_wr_lo    (tmr_wr_lo),
  .pc_sel_irq   (pc_sel_irq),
  .fetch_go     (fetch_go),
  .tmr_count    (tmr_count)
);

// File: tb/sim_fm_fetch_mode_ctl.sv
module sim_fm_fetch_mode_ctl;

  localparam int BW   = 8;
  localparam int FULL = 1 << BW;

  logic clk = 1'b0;
  logic rst_n;
  logic irq_line, fetch_req, prev_cascade, cur_skip, tmr_wr_hi, tmr_wr_lo;
  logic [BW-1:0]   tmr_wdata;
  logic            pc_sel_irq, zp_hi, fetch_go;
  logic [1:0]      fetch_mode;
  logic [2*BW-1:0] tmr_count;

  always #10 clk = ~clk;

  fm_fetch_mode_ctl #(.BYTE_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .fetch_req(fetch_req),
    .prev_cascade(prev_cascade), .cur_skip(cur_skip),
    .tmr_wr_hi(tmr_wr_hi), .tmr_wr_lo(tmr_wr_lo), .tmr_wdata(tmr_wdata),
    .pc_sel_irq(pc_sel_irq), .zp_hi(zp_hi), .fetch_go(fetch_go),
    .fetch_mode(fetch_mode), .tmr_count(tmr_count)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference state
  bit m_irq, m_wait, m_pend, m_brw;
  int m_hi, m_lo;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic int exp_mode();
    if (m_wait && !m_irq) return 2;
    if (m_irq)            return 1;
    return 0;
  endfunction

  task automatic compare_all();
    chk("R4 pc_sel_irq", int'(pc_sel_irq), int'(m_irq));
    chk("R4 zp_hi", int'(zp_hi), int'(m_irq));
    chk("R4 fetch_mode", int'(fetch_mode), exp_mode());
    chk("R6 fetch_go", int'(fetch_go), int'(!(m_wait && !m_irq)));
    chk("R8 tmr_count", int'(tmr_count), m_hi * FULL + m_lo);
  endtask

  // Drive one cycle, advance the reference, then check after the edge.
  task automatic step(input bit fr, input bit pc, input bit sk,
                      input bit whi, input bit wlo, input int wd, input bit irq);
    bit stl, sw, nb, reach, wz;
    int nh, nl;
    fetch_req = fr; prev_cascade = pc; cur_skip = sk;
    tmr_wr_hi = whi; tmr_wr_lo = wlo; tmr_wdata = BW'(wd); irq_line = irq;
    stl = m_wait && !m_irq;
    sw  = fr && !pc && !sk && !stl;
    nh = m_hi; nl = m_lo; nb = m_brw; reach = 0;
    if (whi || wlo) begin
      if (whi) nh = wd;
      if (wlo) nl = wd;
      nb = 0;
    end else if (stl) begin
      if (m_brw)          begin nh = m_hi - 1; nb = 0; end
      else if (m_lo != 0) nl = m_lo - 1;
      else                begin nl = FULL - 2; nb = 1; end
      reach = (nh == 0 && nl == 0 && !nb);
    end
    wz = wlo && nh == 0 && nl == 0;
    if (sw)              m_irq = irq;
    else if (stl && irq) m_irq = 1;
    if (wz || reach)               m_wait = 0;
    else if (sw && !irq && m_pend) m_wait = 1;
    if (wz || reach) m_pend = 0;
    else if (wlo)    m_pend = 1;
    m_hi = nh; m_lo = nl; m_brw = nb;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input bit irq);
    step(0, 0, 0, 0, 0, 0, irq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    bit irq_r;
    void'($urandom(32'd4711));
    rst_n = 0;
    fetch_req = 0; prev_cascade = 0; cur_skip = 0;
    tmr_wr_hi = 0; tmr_wr_lo = 0; tmr_wdata = '0; irq_line = 0;
    m_irq = 0; m_wait = 0; m_pend = 0; m_brw = 0; m_hi = 0; m_lo = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 tmr_count", int'(tmr_count), 0);
    chk("R1 pc_sel_irq", int'(pc_sel_irq), 0);
    chk("R1 fetch_go", int'(fetch_go), 1);
    chk("R1 fetch_mode", int'(fetch_mode), 0);
    rst_n = 1;
    idle(0);

    // R2: entry and exit only at fetch points
    idle(1);
    chk("R2 no fetch point", int'(pc_sel_irq), 0);
    step(1, 0, 0, 0, 0, 0, 1);
    chk("R2 entry", int'(pc_sel_irq), 1);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R2 exit", int'(pc_sel_irq), 0);

    // R3: cascade and skip defer entry and exit
    step(1, 1, 0, 0, 0, 0, 1);
    chk("R3 cascade defers entry", int'(pc_sel_irq), 0);
    step(1, 0, 1, 0, 0, 0, 1);
    chk("R3 skip defers entry", int'(pc_sel_irq), 0);
    step(1, 0, 0, 0, 0, 0, 1);
    chk("R3 later entry", int'(pc_sel_irq), 1);
    step(1, 1, 0, 0, 0, 0, 0);
    chk("R3 cascade defers exit", int'(pc_sel_irq), 1);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R3 later exit", int'(pc_sel_irq), 0);

    // R5: high-byte write alone does not arm
    step(0, 0, 0, 1, 0, 2, 0);
    chk("R5 count shows high byte", int'(tmr_count), 2 * FULL);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R5 no stall", int'(fetch_go), 1);

    // R7: zero low write disarms
    step(0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 5, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R7 disarmed", int'(fetch_go), 1);

    // R3: timer start deferred by skip
    step(0, 0, 0, 0, 1, 4, 0);
    step(1, 0, 1, 0, 0, 0, 0);
    chk("R3 skip defers timer", int'(fetch_go), 1);

    // R6: stall length for V = 4
    step(1, 0, 0, 0, 0, 0, 0);
    n = 0;
    while (!fetch_go && n < 100000) begin idle(0); n++; end
    chk("R6 stall length 4", n, 4);

    // R6: V = 259 across one borrow
    step(0, 0, 0, 1, 0, 1, 0);
    step(0, 0, 0, 0, 1, 3, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    n = 0;
    while (!fetch_go && n < 100000) begin idle(0); n++; end
    chk("R6 stall length 259", n, 259);
    chk("R6 count zero", int'(tmr_count), 0);

    // R8: borrow sequence from {2,0}
    step(0, 0, 0, 1, 0, 2, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    idle(0);
    chk("R8 low wraps", int'(tmr_count), 2 * FULL + FULL - 2);
    idle(0);
    chk("R8 high steps", int'(tmr_count), FULL + FULL - 2);
    idle(0);
    chk("R8 low resumes", int'(tmr_count), FULL + FULL - 3);
    n = 3;
    while (!fetch_go && n < 100000) begin idle(0); n++; end
    chk("R6 stall length 512", n, 512);

    // R9 and R10: interrupt during wait, then resume
    step(0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 40, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    repeat (10) idle(0);
    chk("R9 counted down", int'(tmr_count), 30);
    idle(1);
    chk("R9 entry in stall", int'(pc_sel_irq), 1);
    chk("R9 fetch resumes", int'(fetch_go), 1);
    repeat (5) idle(1);
    chk("R9 frozen", int'(tmr_count), 29);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R10 stall resumes", int'(fetch_go), 0);
    n = 0;
    while (!fetch_go && n < 100000) begin idle(0); n++; end
    chk("R10 remaining cycles", n, 29);

    // R11: handler cancels remaining wait
    step(0, 0, 0, 0, 1, 50, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    repeat (5) idle(0);
    idle(1);
    step(0, 0, 0, 0, 1, 0, 1);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R11 exit to fetch", int'(fetch_go), 1);
    chk("R11 normal pair", int'(pc_sel_irq), 0);

    // Random phase
    irq_r = 0;
    for (int i = 0; i < 4000; i++) begin
      bit fr, pc, sk, whi, wlo;
      int wd;
      if ($urandom_range(99) < 3) irq_r = !irq_r;
      fr = 0; pc = 0; sk = 0; whi = 0; wlo = 0; wd = 0;
      if (fetch_go) begin
        fr  = ($urandom_range(99) < 40);
        pc  = ($urandom_range(99) < 15);
        sk  = ($urandom_range(99) < 15);
        if ($urandom_range(99) < 10) begin
          if ($urandom_range(1) == 0) begin
            whi = 1;
            wd  = ($urandom_range(9) == 0) ? 1 : 0;
          end else begin
            wlo = 1;
            wd  = $urandom_range(20);
          end
        end
      end
      step(fr, pc, sk, whi, wlo, wd, irq_r);
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule